// File: doc/BRIEF.md
# Banked Stack Pointer with Reset Vector Loader

This block keeps the two stack pointer banks of a small processor core, main and process, and presents them as one architectural stack pointer. The bank that is visible depends on the execution mode and on a stack-select bit in a control register. In handler mode the main bank is always used. In thread mode the control bit chooses between the two banks. Stack pointer writes always land in the bank that is visible at that moment. The low two bits of every stored value are forced to zero.

After reset the block fetches its start-up state over a simple read port. It reads one word at a time and waits for a response before going on. The word at address 0x00000000 becomes the initial main stack pointer. The word at address 0x00000004 becomes the program counter, and its bit 0 becomes the T bit. The link register comes out of reset as all ones. A done flag tells the rest of the core when start-up has finished. Until that flag is set, writes to the stack pointer and to the control register have no effect.

Top module: `sp_bank_top`

## Requirements
- R1: In thread mode (`handler_mode_i`=0) with the stack-select bit at 1, `sp_rdata_o` returns the process bank, and `sp_we_i` writes into the process bank.
- R2: In handler mode (`handler_mode_i`=1), `sp_rdata_o` returns the main bank and `sp_we_i` writes into the main bank, whatever the stack-select bit holds.
- R3: The stack-select bit (`ctrl_spsel_o`) resets to 0 and is loaded from bit 1 of `ctrl_wdata_i` when `ctrl_we_i` is high. The load happens only when `priv_i` is 1 and `reset_done_o` is 1. Any other control write leaves the bit unchanged.
- R4: After reset the first read is issued with `mem_addr_o`=0x00000000. Its response word, with bits 1:0 cleared, becomes the main bank value.
- R5: The second read is issued with `mem_addr_o`=0x00000004. Its response word, with bit 0 cleared, is loaded into `pc_o`, and bit 0 of that word is loaded into `tbit_o`.
- R6: Only one read is outstanding at a time. While `mem_req_o` is high and no `mem_rvalid_i` has arrived, both the request and its address hold steady.
- R7: `lr_o` reads 0xFFFFFFFF from reset onward.
- R8: Every value written through `sp_we_i` is stored with bits 1:0 forced to zero.
- R9: `reset_done_o` is 0 from reset until the cycle after the second response, and then stays at 1. After that point `mem_req_o` stays low, and `mem_rvalid_i` pulses have no effect.
- R10: While `reset_done_o` is 0, `sp_we_i` has no effect on either stack pointer bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| handler_mode_i | input | 1 | 1 = handler mode, 0 = thread mode |
| priv_i | input | 1 | 1 = current software is privileged |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control write data; bit 1 is the stack-select bit |
| ctrl_spsel_o | output | 1 | Current stack-select bit |
| sp_we_i | input | 1 | Stack pointer write strobe |
| sp_wdata_i | input | 32 | Stack pointer write data |
| sp_rdata_o | output | 32 | Stack pointer of the bank in use |
| mem_req_o | output | 1 | Vector read request |
| mem_addr_o | output | 32 | Vector read address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| pc_o | output | 32 | Program counter loaded from the reset vector |
| lr_o | output | 32 | Link register |
| tbit_o | output | 1 | T bit taken from bit 0 of the reset vector |
| reset_done_o | output | 1 | Start-up fetch finished |

## Verification
The bench holds back read responses for several cycles and checks that the request and its address stay stable while it waits. A loader that skipped ahead or changed the address would make it load the wrong vector into the stack pointer or the program counter. It sends stack pointer and control writes during start-up, and it issues control writes with the privilege input low. A design that failed to block either kind of write would show a changed bank or a changed select bit on the next cycle. It switches into handler mode while the select bit is 1, so that a design that forgot the mode override would show the process bank. It writes stack values with the low bits set and sends stray responses after start-up has finished. A second reset uses an even vector to check that the T bit can also come back as zero.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_SP   = 2'd1,
    LD_PC   = 2'd2,
    LD_DONE = 2'd3
  } ld_state_e;
endpackage

// File: rtl/sp_reset_loader.sv
module sp_reset_loader
  import sp_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] SP_VEC_ADDR = '0,
  parameter logic [AW-1:0] PC_VEC_ADDR = AW'(4)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          msp_load_o,
  output logic [DW-1:0] msp_init_o,
  output logic [DW-1:0] pc_o,
  output logic          tbit_o,
  output logic          done_o
);
  ld_state_e state_q, state_d;
  logic [DW-1:0] pc_q;
  logic          tbit_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_IDLE: state_d = LD_SP;
      LD_SP:   if (mem_rvalid_i) state_d = LD_PC;
      LD_PC:   if (mem_rvalid_i) state_d = LD_DONE;
      default: state_d = LD_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LD_IDLE;
      pc_q    <= '0;
      tbit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == LD_PC && mem_rvalid_i) begin
        pc_q   <= {mem_rdata_i[DW-1:1], 1'b0};
        tbit_q <= mem_rdata_i[0];
      end
    end
  end

  assign mem_req_o  = (state_q == LD_SP) || (state_q == LD_PC);
  assign mem_addr_o = (state_q == LD_PC) ? PC_VEC_ADDR : SP_VEC_ADDR;
  assign msp_load_o = (state_q == LD_SP) && mem_rvalid_i;
  assign msp_init_o = mem_rdata_i;
  assign pc_o       = pc_q;
  assign tbit_o     = tbit_q;
  assign done_o     = (state_q == LD_DONE);

  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  p_done_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);
  p_pc_even_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pc_o[0] == 1'b0));
endmodule

// File: rtl/sp_ctrl_reg.sv
module sp_ctrl_reg #(
  parameter int unsigned DW      = 32,
  parameter int unsigned SEL_BIT = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic          priv_i,
  input  logic [DW-1:0] wdata_i,
  output logic          spsel_o
);
  logic spsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) spsel_q <= 1'b0;
    else if (en_i && we_i && priv_i) spsel_q <= wdata_i[SEL_BIT];
  end

  assign spsel_o = spsel_q;

  p_unpriv_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv_i) |=> $stable(spsel_o));
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int unsigned DW         = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_load_i,
  input  logic [DW-1:0] init_data_i,
  input  logic          use_psp_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam logic [DW-1:0] ALIGN_MASK = ~((DW)'((1 << ALIGN_BITS) - 1));

  logic [DW-1:0] msp_q;
  logic [DW-1:0] psp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) msp_q <= '0;
    else if (init_load_i) msp_q <= init_data_i & ALIGN_MASK;
    else if (we_i && !use_psp_i) msp_q <= wdata_i & ALIGN_MASK;
  end

  // process bank has no defined reset value
  always_ff @(posedge clk_i) begin
    if (we_i && use_psp_i) psp_q <= wdata_i & ALIGN_MASK;
  end

  assign rdata_o = use_psp_i ? psp_q : msp_q;

  p_msp_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !use_psp_i && !init_load_i) |=> (msp_q == ($past(wdata_i) & ALIGN_MASK)));
  p_psp_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && use_psp_i) |=> (psp_q[ALIGN_BITS-1:0] == '0));
  p_psp_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && use_psp_i) |=> (psp_q == ($past(wdata_i) & ALIGN_MASK)));
endmodule

// File: rtl/sp_bank_top.sv
module sp_bank_top #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 32,
  parameter int unsigned SEL_BIT = 1,
  parameter int unsigned ALIGN_BITS = 2,
  parameter logic [AW-1:0] SP_VEC_ADDR = '0,
  parameter logic [AW-1:0] PC_VEC_ADDR = AW'(4)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          handler_mode_i,
  input  logic          priv_i,
  input  logic          ctrl_we_i,
  input  logic [DW-1:0] ctrl_wdata_i,
  output logic          ctrl_spsel_o,
  input  logic          sp_we_i,
  input  logic [DW-1:0] sp_wdata_i,
  output logic [DW-1:0] sp_rdata_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] lr_o,
  output logic          tbit_o,
  output logic          reset_done_o
);
  logic          done;
  logic          msp_load;
  logic [DW-1:0] msp_init;
  logic          spsel;
  logic          use_psp;
  logic [DW-1:0] lr_q;

  sp_reset_loader #(
    .DW(DW), .AW(AW), .SP_VEC_ADDR(SP_VEC_ADDR), .PC_VEC_ADDR(PC_VEC_ADDR)
  ) u_loader (
    .clk_i, .rst_ni,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .msp_load_o(msp_load), .msp_init_o(msp_init),
    .pc_o, .tbit_o, .done_o(done)
  );

  sp_ctrl_reg #(.DW(DW), .SEL_BIT(SEL_BIT)) u_ctrl (
    .clk_i, .rst_ni, .en_i(done), .we_i(ctrl_we_i), .priv_i,
    .wdata_i(ctrl_wdata_i), .spsel_o(spsel)
  );

  assign use_psp = !handler_mode_i && spsel;

  sp_bank #(.DW(DW), .ALIGN_BITS(ALIGN_BITS)) u_bank (
    .clk_i, .rst_ni,
    .init_load_i(msp_load), .init_data_i(msp_init),
    .use_psp_i(use_psp), .we_i(sp_we_i && done), .wdata_i(sp_wdata_i),
    .rdata_o(sp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lr_q <= '1;
    else lr_q <= lr_q;
  end

  assign lr_o         = lr_q;
  assign ctrl_spsel_o = spsel;
  assign reset_done_o = done;

  p_lr_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_o == '1);
  p_early_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_we_i && !reset_done_o && !mem_rvalid_i && !handler_mode_i && !ctrl_spsel_o)
      |=> $stable(sp_rdata_o) || !$stable(handler_mode_i) || !$stable(ctrl_spsel_o));
  p_handler_main_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (handler_mode_i && $past(handler_mode_i) && !$past(sp_we_i) && !$past(mem_rvalid_i))
      |-> $stable(sp_rdata_o));
endmodule

// File: tb/sim_sp_bank_top.sv
module sim_sp_bank_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        handler_mode = 1'b0;
  logic        priv = 1'b1;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        sp_we = 1'b0;
  logic [31:0] sp_wdata = '0;
  logic        rvalid = 1'b0;
  logic [31:0] rdata = '0;
  logic        ctrl_spsel, mem_req, tbit, reset_done;
  logic [31:0] sp_rdata, mem_addr, pc, lr;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // responder settings
  int          resp_delay = 3;
  int          resp_cnt = 0;
  bit          stray = 0;
  logic [31:0] vec_sp = 32'h2000_1003;
  logic [31:0] vec_pc = 32'h0000_0125;

  always #4 clk = ~clk;

  sp_bank_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .handler_mode_i(handler_mode), .priv_i(priv),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_spsel_o(ctrl_spsel),
    .sp_we_i(sp_we), .sp_wdata_i(sp_wdata), .sp_rdata_o(sp_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(rvalid),
    .mem_rdata_i(rdata), .pc_o(pc), .lr_o(lr), .tbit_o(tbit),
    .reset_done_o(reset_done)
  );

  // reference model
  int          m_st;
  logic [31:0] m_msp, m_psp, m_pc;
  bit          m_psp_ok, m_spsel, m_t;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_msp = '0; m_pc = '0; m_t = 0; m_spsel = 0; m_psp_ok = 0;
    end else begin
      case (m_st)
        0: m_st = 1;
        1: if (rvalid) begin m_msp = rdata & 32'hFFFF_FFFC; m_st = 2; end
        2: if (rvalid) begin m_pc = rdata & 32'hFFFF_FFFE; m_t = rdata[0]; m_st = 3; end
        default: begin
          if (sp_we) begin
            if (!handler_mode && m_spsel) begin m_psp = sp_wdata & 32'hFFFF_FFFC; m_psp_ok = 1; end
            else m_msp = sp_wdata & 32'hFFFF_FFFC;
          end
          if (ctrl_we && priv) m_spsel = ctrl_wdata[1];
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, at the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(reset_done == (m_st == 3), "R9 done", {31'b0, reset_done}, {31'b0, m_st == 3});
      check(mem_req == (m_st == 1 || m_st == 2), "R6 req", {31'b0, mem_req}, {31'b0, m_st == 1 || m_st == 2});
      if (m_st == 1) check(mem_addr == 32'h0, "R4 addr", mem_addr, 32'h0);
      if (m_st == 2) check(mem_addr == 32'h4, "R5 addr", mem_addr, 32'h4);
      check(pc == m_pc, "R5 pc", pc, m_pc);
      check(tbit == m_t, "R5 tbit", {31'b0, tbit}, {31'b0, m_t});
      check(lr == 32'hFFFF_FFFF, "R7 lr", lr, 32'hFFFF_FFFF);
      check(ctrl_spsel == m_spsel, "R3 spsel", {31'b0, ctrl_spsel}, {31'b0, m_spsel});
      if (handler_mode)
        check(sp_rdata == m_msp, "R2 sp handler", sp_rdata, m_msp);
      else if (m_spsel) begin
        if (m_psp_ok) check(sp_rdata == m_psp, "R1 sp process", sp_rdata, m_psp);
      end else if (m_st == 3)
        check(sp_rdata == m_msp, "R8 sp main", sp_rdata, m_msp);
      else
        check(sp_rdata == m_msp, "R10 sp early", sp_rdata, m_msp);
    end
  end

  // vector memory responder
  always begin
    @(posedge clk); #2;
    if (mem_req) begin
      if (resp_cnt >= resp_delay) begin
        rvalid = 1'b1;
        rdata = (mem_addr == 32'h4) ? vec_pc : vec_sp;
        resp_cnt = 0;
      end else begin
        rvalid = 1'b0;
        rdata = 32'hDEAD_BEEF;
        resp_cnt++;
      end
    end else begin
      rvalid = stray;
      rdata = 32'h5555_5555;
      resp_cnt = 0;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic sp_write(input logic [31:0] v);
    sp_we = 1; sp_wdata = v; step(); sp_we = 0;
  endtask

  task automatic ctrl_write(input logic [31:0] v, input bit p);
    ctrl_we = 1; ctrl_wdata = v; priv = p; step(); ctrl_we = 0; priv = 1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    // R10 and R3: writes during start-up are ignored
    step(1);
    sp_write(32'h7777_7770);
    ctrl_write(32'h2, 1);
    wait (reset_done); step(1);
    // R8: aligned write to main bank
    sp_write(32'h1000_0007); step(1);
    // R3: unprivileged write ignored, then privileged write takes effect
    ctrl_write(32'h2, 0); step(1);
    ctrl_write(32'h2, 1); step(1);
    // R1: process bank
    sp_write(32'h3000_0002); step(2);
    // R2: handler mode overrides select bit
    handler_mode = 1; step(2);
    sp_write(32'h4000_0001); step(1);
    handler_mode = 0; step(2);
    sp_write(32'h3000_0010); step(1);
    ctrl_write(32'h0, 0); step(1);
    ctrl_write(32'hFFFF_FFFD, 1); step(2);
    // R9: stray responses after start-up
    stray = 1; step(4); stray = 0; step(1);
    // second reset: even vector, immediate responses
    rst_n = 0; step(2);
    resp_delay = 0; vec_sp = 32'h2000_0800; vec_pc = 32'h0800_0200;
    rst_n = 1;
    wait (reset_done); step(2);
    check(tbit == 1'b0, "R5 even vector", {31'b0, tbit}, 32'h0);
    sp_write(32'h1234_567B); step(2);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R9 actual=%08h expected=%08h", 32'h0, 32'h1);
      finish_run();
    end
  end
endmodule